// File: doc/BRIEF.md
# Two-Tier Configuration Bit Store

This block keeps a bank of configuration bits for the rest of the chip. Each bit has two storage tiers. The first is a volatile shadow bit, which any reset clears. The second is a write-once permanent cell, modelled as a sticky register that starts at 0, can only be set, and is untouched by every reset. The effective value of a bit is the OR of its two tiers. A programmed 1 therefore cannot be overridden, and a temporary write can only raise bits whose permanent cell is still blank.

Commands arrive on a single write port that carries a bit address, a data bit and a mode bit. Mode 0 is a temporary write to the shadow tier. Mode 1 is a permanent write to the cell, and it is only accepted when a programming-enable input is high in the same cycle. A separate read port returns the shadow, permanent and effective values of one bit. The full effective word is driven from a register, so the rest of the chip sees it without any handshake. A one-cycle remote-reset pulse clears the shadow tier only.

Top module: `cfg_store_bank`

## Requirements
- R1: After `rst` is held high for at least one rising edge, `err_o` and `rd_vld_o` are 0. While no permanent cell is programmed, `cfg_word_o` is 0 and every readback returns 0.
- R2: A temporary write (`wr_valid_i`=1, `wr_perm_i`=0) stores `wr_data_i` into the shadow bit at `wr_addr_i` on that rising edge. It can set or clear the bit, and no other bit changes.
- R3: A permanent write (`wr_perm_i`=1) with `prog_en_i`=1 and `wr_data_i`=1 sets the permanent cell at `wr_addr_i`. A permanent write with data 0 leaves the cell as it is. A set cell never returns to 0.
- R4: A `soft_clr_i` pulse clears every shadow bit on that edge and leaves the permanent cells unchanged. If a temporary write arrives on the same edge, the clear takes priority.
- R5: `rst` clears every shadow bit and leaves every permanent cell unchanged.
- R6: A permanent write while `prog_en_i`=0 is ignored. `err_o` is 1 for exactly the cycle after such a write and is 0 after any other cycle.
- R7: Bit i of `cfg_word_o` equals shadow bit i OR permanent cell i. The value is registered, so a write sampled on edge k first shows on `cfg_word_o` after edge k+1.
- R8: A read request (`rd_req_i`=1) sampled on edge k sets `rd_vld_o` to 1 after that edge. It also drives `rd_shadow_o`, `rd_otp_o` and `rd_eff_o` with the values that bit held just before edge k. `rd_vld_o` is 0 after any edge without a request.
- R9: An address of NBITS or above is out of range. A write to it changes nothing, and a read of it returns 0 on all three data outputs, with `rd_vld_o` still set.
- R10: A temporary write of 0 to a bit whose permanent cell is set leaves its effective value at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_clr_i | input | 1 | One-cycle remote reset pulse; clears the shadow tier |
| wr_valid_i | input | 1 | Write command strobe |
| wr_addr_i | input | AW | Bit address of the write |
| wr_data_i | input | 1 | Bit value to write |
| wr_perm_i | input | 1 | 0 = temporary (shadow) write, 1 = permanent write |
| prog_en_i | input | 1 | Permits a permanent write in the same cycle |
| rd_req_i | input | 1 | Readback request |
| rd_addr_i | input | AW | Bit address to read back |
| rd_vld_o | output | 1 | Readback data valid |
| rd_shadow_o | output | 1 | Shadow value of the read bit |
| rd_otp_o | output | 1 | Permanent value of the read bit |
| rd_eff_o | output | 1 | Effective value of the read bit |
| err_o | output | 1 | Rejected permanent write, one-cycle pulse |
| cfg_word_o | output | NBITS | Effective configuration word |

## Verification
The bench builds the bank with NBITS=10, so the address is 4 bits wide. This puts all ten valid addresses and the six out-of-range codes within reach of a complete sweep. Every address gets a temporary set, a temporary clear, a readback and a comparison of the whole effective word. The small width also lets the permanent tier be programmed at several points inside one run. Later resets then show that the programmed bits survive, together with the one-edge lag of the word and the priority of the clear over a simultaneous write.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic {
    WR_TEMP = 1'b0,
    WR_PERM = 1'b1
  } wr_mode_e;

  typedef struct packed {
    logic shadow;
    logic otp;
    logic eff;
  } bit_view_t;
endpackage

// File: rtl/cfgb_cmd_decode.sv
module cfgb_cmd_decode
  import cfgb_pkg::*;
#(
  parameter int NBITS = 112,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_perm,
  input  logic             prog_en,
  output logic [NBITS-1:0] sh_we,
  output logic [NBITS-1:0] otp_we,
  output logic             err_o
);
  wr_mode_e mode;
  logic     sel_temp, sel_perm, bad_perm;
  logic     err_q;

  assign mode     = wr_mode_e'(wr_perm);
  assign sel_temp = wr_valid && (mode == WR_TEMP);
  assign sel_perm = wr_valid && (mode == WR_PERM) && prog_en;
  assign bad_perm = wr_valid && (mode == WR_PERM) && !prog_en;

  for (genvar i = 0; i < NBITS; i++) begin : g_dec
    logic hit;
    assign hit       = (wr_addr == AW'(i));
    assign sh_we[i]  = sel_temp && hit;
    assign otp_we[i] = sel_perm && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= bad_perm;
  end
  assign err_o = err_q;

  // R6: rejected permanent write raises the flag for the next cycle only
  p_err_raise_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_perm && !prog_en) |=> err_o);
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_perm && !prog_en) |=> !err_o);
  // R2: at most one shadow bit is targeted per cycle
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sh_we | otp_we));
endmodule

// File: rtl/cfgb_shadow_bank.sv
module cfgb_shadow_bank #(
  parameter int NBITS = 112
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [NBITS-1:0] we,
  input  logic             wdata,
  output logic [NBITS-1:0] q
);
  logic [NBITS-1:0] sh_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)  sh_q[i] <= 1'b0;
      else if (we[i])  sh_q[i] <= wdata;
    end
  end
  assign q = sh_q;

  // R4: a remote clear empties the shadow tier on the next edge
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
  // R5: power-on reset empties the shadow tier
  p_por_clear_r5: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/cfgb_otp_bank.sv
module cfgb_otp_bank #(
  parameter int NBITS = 112
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] we,
  input  logic             wdata,
  output logic [NBITS-1:0] q
);
  // Permanent cells: blank (0) at start, no reset, set-only
  logic [NBITS-1:0] cell_q = '0;
  logic             past_ok = 1'b0;

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we[i] && wdata) cell_q[i] <= 1'b1;
    end
  end
  assign q = cell_q;

  always_ff @(posedge clk) past_ok <= 1'b1;

  // R3: a set cell never goes back to 0
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/cfg_store_bank.sv
module cfg_store_bank
  import cfgb_pkg::*;
#(
  parameter  int NBITS = 112,
  localparam int AW    = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_clr_i,
  input  logic             wr_valid_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic             wr_data_i,
  input  logic             wr_perm_i,
  input  logic             prog_en_i,
  input  logic             rd_req_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             rd_vld_o,
  output logic             rd_shadow_o,
  output logic             rd_otp_o,
  output logic             rd_eff_o,
  output logic             err_o,
  output logic [NBITS-1:0] cfg_word_o
);
  localparam logic [AW:0] LIMIT = (AW+1)'(NBITS);

  logic [NBITS-1:0] sh_we, otp_we, sh_q, otp_q, word_q;
  logic             rd_vld_q, rd_ok;
  bit_view_t        view_q;
  logic             past_ok = 1'b0;

  cfgb_cmd_decode #(.NBITS(NBITS), .AW(AW)) u_dec (
    .clk(clk), .rst(rst), .wr_valid(wr_valid_i), .wr_addr(wr_addr_i),
    .wr_perm(wr_perm_i), .prog_en(prog_en_i),
    .sh_we(sh_we), .otp_we(otp_we), .err_o(err_o)
  );

  cfgb_shadow_bank #(.NBITS(NBITS)) u_sh (
    .clk(clk), .rst(rst), .clr(soft_clr_i), .we(sh_we),
    .wdata(wr_data_i), .q(sh_q)
  );

  cfgb_otp_bank #(.NBITS(NBITS)) u_otp (
    .clk(clk), .rst(rst), .we(otp_we), .wdata(wr_data_i), .q(otp_q)
  );

  assign rd_ok = ({1'b0, rd_addr_i} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      rd_vld_q <= 1'b0;
      view_q   <= '0;
    end else begin
      word_q   <= sh_q | otp_q;
      rd_vld_q <= rd_req_i;
      if (rd_req_i) begin
        if (rd_ok) begin
          view_q.shadow <= sh_q[rd_addr_i];
          view_q.otp    <= otp_q[rd_addr_i];
          view_q.eff    <= sh_q[rd_addr_i] | otp_q[rd_addr_i];
        end else begin
          view_q <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) past_ok <= 1'b1;

  assign cfg_word_o  = word_q;
  assign rd_vld_o    = rd_vld_q;
  assign rd_shadow_o = view_q.shadow;
  assign rd_otp_o    = view_q.otp;
  assign rd_eff_o    = view_q.eff;

  // R6: a permanent cell only changes after an enabled permanent write
  p_otp_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && (otp_q != $past(otp_q))) |-> $past(prog_en_i && wr_valid_i && wr_perm_i));
  // R9: out-of-range reads return zeros
  p_range_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req_i && !rd_ok) |=> (rd_vld_o && !rd_shadow_o && !rd_otp_o && !rd_eff_o));
  // R8: valid follows the request by one edge
  p_rd_vld_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req_i |=> rd_vld_o);
endmodule

// File: tb/sim_cfg_store_bank.sv
module sim_cfg_store_bank;
  localparam int NB = 10;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_clr = 1'b0, wr_valid = 1'b0, wr_data = 1'b0, wr_perm = 1'b0;
  logic prog_en = 1'b0, rd_req = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic rd_vld, rd_sh, rd_ot, rd_eff, err;
  logic [NB-1:0] cfg_word;

  logic [NB-1:0] m_sh = '0, m_ot = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cfg_store_bank #(.NBITS(NB)) u0 (
    .clk(clk), .rst(rst), .soft_clr_i(soft_clr), .wr_valid_i(wr_valid),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_perm_i(wr_perm),
    .prog_en_i(prog_en), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_vld_o(rd_vld), .rd_shadow_o(rd_sh), .rd_otp_o(rd_ot),
    .rd_eff_o(rd_eff), .err_o(err), .cfg_word_o(cfg_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input int a, input bit d, input bit perm, input bit en,
                       input string req);
    logic [NB-1:0] old;
    old = m_sh | m_ot;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d; wr_perm = perm; prog_en = en;
    @(negedge clk);
    wr_valid = 1'b0; prog_en = 1'b0;
    if (a < NB) begin
      if (!perm) m_sh[a] = d;
      else if (en && d) m_ot[a] = 1'b1;
    end
    chk(err == (perm && !en), "R6", "err after write", 32'(err), 32'(perm && !en));
    chk(cfg_word == old, "R7", "word before lag edge", 32'(cfg_word), 32'(old));
    @(negedge clk);
    chk(cfg_word == (m_sh | m_ot), req, "cfg_word", 32'(cfg_word), 32'(m_sh | m_ot));
    chk(err == 1'b0, "R6", "err pulse length", 32'(err), 0);
  endtask

  task automatic do_rd(input int a, input string req);
    bit es, eo;
    es = (a < NB) ? m_sh[a] : 1'b0;
    eo = (a < NB) ? m_ot[a] : 1'b0;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_vld == 1'b1, "R8", "rd_vld", 32'(rd_vld), 1);
    chk(rd_sh == es, req, "rd_shadow", 32'(rd_sh), 32'(es));
    chk(rd_ot == eo, req, "rd_otp", 32'(rd_ot), 32'(eo));
    chk(rd_eff == (es | eo), req, "rd_eff", 32'(rd_eff), 32'(es | eo));
    @(negedge clk);
    chk(rd_vld == 1'b0, "R8", "rd_vld drop", 32'(rd_vld), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(cfg_word == '0, "R1", "cfg_word after reset", 32'(cfg_word), 0);
    chk(err == 1'b0, "R1", "err after reset", 32'(err), 0);
    chk(rd_vld == 1'b0, "R1", "rd_vld after reset", 32'(rd_vld), 0);
    for (int a = 0; a < 16; a++) do_rd(a, "R1");

    // R2, R9: temporary set sweep across every address code
    for (int a = 0; a < 16; a++) begin
      do_wr(a, 1'b1, 1'b0, 1'b0, (a < NB) ? "R2" : "R9");
      do_rd(a, (a < NB) ? "R2" : "R9");
    end
    // R2: clear even bits
    for (int a = 0; a < NB; a += 2) do_wr(a, 1'b0, 1'b0, 1'b0, "R2");
    for (int a = 0; a < NB; a++) do_rd(a, "R2");

    // R4: remote clear with a simultaneous temporary write
    @(negedge clk);
    soft_clr = 1'b1; wr_valid = 1'b1; wr_addr = 4'd4; wr_data = 1'b1; wr_perm = 1'b0;
    @(negedge clk);
    soft_clr = 1'b0; wr_valid = 1'b0;
    m_sh = '0;
    @(negedge clk);
    chk(cfg_word == m_ot, "R4", "word after remote clear", 32'(cfg_word), 32'(m_ot));
    do_rd(4, "R4");

    // R6: permanent write without enable is ignored
    do_wr(1, 1'b1, 1'b1, 1'b0, "R6");
    do_rd(1, "R6");

    // R3, R9: program cells, including an out-of-range code
    do_wr(2, 1'b1, 1'b1, 1'b1, "R3");
    do_wr(5, 1'b1, 1'b1, 1'b1, "R3");
    do_wr(9, 1'b1, 1'b1, 1'b1, "R3");
    do_wr(12, 1'b1, 1'b1, 1'b1, "R9");
    do_wr(7, 1'b0, 1'b1, 1'b1, "R3");
    do_wr(2, 1'b0, 1'b1, 1'b1, "R3");
    for (int a = 0; a < 16; a++) do_rd(a, (a < NB) ? "R3" : "R9");

    // R10: temporary 0 on a programmed bit
    do_wr(5, 1'b1, 1'b0, 1'b0, "R10");
    do_wr(5, 1'b0, 1'b0, 1'b0, "R10");
    do_rd(5, "R10");

    // R4 again: cells survive remote clear
    do_wr(0, 1'b1, 1'b0, 1'b0, "R2");
    @(negedge clk); soft_clr = 1'b1;
    @(negedge clk); soft_clr = 1'b0; m_sh = '0;
    @(negedge clk);
    chk(cfg_word == m_ot, "R4", "cells kept after clear", 32'(cfg_word), 32'(m_ot));

    // R5: power-on reset keeps cells, clears shadow
    do_wr(3, 1'b1, 1'b0, 1'b0, "R2");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; m_sh = '0;
    chk(cfg_word == '0, "R5", "word register after reset", 32'(cfg_word), 0);
    @(negedge clk);
    chk(cfg_word == m_ot, "R5", "cells kept after reset", 32'(cfg_word), 32'(m_ot));
    for (int a = 0; a < NB; a++) do_rd(a, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule